// File: doc/BRIEF.md
# Interrupt Priority and Vectoring Controller

This block decides when the processor core should break into an interrupt service routine, and which routine it should enter. Every source has a request flag, an enable bit and a one-bit priority level. A global enable gates all of them. The core marks each instruction boundary with a strobe, and the controller takes a decision only on that strobe. When a request wins, the controller answers one clock later with four things: a call request, the service-routine address, a push-program-counter command and an acknowledge pulse to the winning source. The status word is never pushed.

The controller keeps one in-progress bit for each of the two levels. A high-level request may break into a low-level routine. No request is served while a routine of the same or a higher level is running. Only the return-from-interrupt strobe ends a routine, and it clears the highest active level. After that strobe the controller sits out one instruction boundary, so at least one instruction of the interrupted program runs before the next entry. Some sources have flags that software must clear, and those sources never receive an acknowledge pulse.

Top module: `intr_vector_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after release, `call_o`, `push_pc_o`, `ack_o` and `vec_addr_o` are all zero.
- R2: A decision is taken only in a cycle where `insn_bnd_i` is 1 and `gie_i` is 1. The resulting `call_o` is high for exactly one cycle, the cycle after that decision. No decision is taken in the cycle right after a call.
- R3: A source is a candidate when its `req_i` bit and its `en_i` bit are both 1. Candidates with `prio_i` = 1 (high) beat candidates with `prio_i` = 0 (low). Within one level, the lowest source index wins.
- R4: When `call_o` is 1, `vec_addr_o` equals 0x0003 + 8 × (winning index). At all other times `vec_addr_o` is 0.
- R5: `push_pc_o` is 1 exactly in the cycles where `call_o` is 1. No other state is saved.
- R6: `ack_o` has the winner's bit set in the call cycle, and only when that bit is set in `ACK_MASK`. With the default mask 0x0F, sources 4 to 7 never see an acknowledge. Outside call cycles `ack_o` is 0.
- R7: A high candidate is blocked only while a high routine is in progress. A low candidate is blocked while a routine of either level is in progress. A high request therefore preempts a running low routine.
- R8: `reti_i` clears the in-progress bit of the high level if that bit is set, and otherwise clears the low bit. Nothing else clears an in-progress bit.
- R9: After `reti_i`, the next cycle with `insn_bnd_i` = 1 takes no decision. A decision is possible only from the boundary after that. A boundary that arrives in the same cycle as `reti_i` takes no decision either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N | Request flag for each source |
| en_i | input | N | Enable bit for each source |
| gie_i | input | 1 | Global interrupt enable |
| prio_i | input | N | Priority level for each source (1 = high) |
| insn_bnd_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| call_o | output | 1 | Vector-call request, one cycle |
| vec_addr_o | output | AW | Service-routine address |
| push_pc_o | output | 1 | Push program counter onto stack |
| ack_o | output | N | Acknowledge pulse for each source |

## Verification
The bench builds the block with its defaults: eight sources, a 16-bit address, base 0x0003, a step of 8 and an acknowledge mask of 0x0F. Eight sources are enough to reach every vector slot from 0x03 to 0x3B. They also cover both halves of the mask, so the bench can compare sources that receive an acknowledge with sources that software must clear. Random mixes of levels let high requests arrive while low routines are running, which exercises preemption. Random return strobes reach the skipped-boundary rule many times over the run.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_LO   = 2'd1,
    GR_HI   = 2'd2
  } grant_e;
endpackage

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |cand;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ivc_level_track.sv
module ivc_level_track
  import ivc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  grant_e grant,
  input  logic   reti,
  input  logic   bnd,
  output logic   busy_hi,
  output logic   busy_lo,
  output logic   skip
);
  logic hi_d, lo_d, skip_d;

  always_comb begin
    hi_d   = busy_hi;
    lo_d   = busy_lo;
    skip_d = skip;
    if (reti) begin
      if (busy_hi) hi_d = 1'b0;
      else         lo_d = 1'b0;
      skip_d = 1'b1;
    end else if (bnd && skip) begin
      skip_d = 1'b0;
    end
    if (grant == GR_HI) hi_d = 1'b1;
    if (grant == GR_LO) lo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_hi <= 1'b0;
      busy_lo <= 1'b0;
      skip    <= 1'b0;
    end else begin
      busy_hi <= hi_d;
      busy_lo <= lo_d;
      skip    <= skip_d;
    end
  end
endmodule

// File: rtl/ivc_vector_out.sv
module ivc_vector_out #(
  parameter int           N        = 8,
  parameter int           IW       = $clog2(N),
  parameter int           AW       = 16,
  parameter int           BASE     = 3,
  parameter int           STEP     = 8,
  parameter logic [N-1:0] ACK_MASK = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] idx,
  output logic          call,
  output logic          push_pc,
  output logic [AW-1:0] vec,
  output logic [N-1:0]  ack
);
  logic [AW-1:0] vec_d;
  logic [N-1:0]  ack_d;

  always_comb begin
    vec_d = fire ? (AW'(BASE) + AW'(STEP) * AW'(idx)) : '0;
  end

  for (genvar g = 0; g < N; g++) begin : g_ack
    if (ACK_MASK[g]) begin : g_hw
      assign ack_d[g] = fire && (idx == IW'(g));
    end else begin : g_sw
      assign ack_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call    <= 1'b0;
      push_pc <= 1'b0;
      vec     <= '0;
      ack     <= '0;
    end else begin
      call    <= fire;
      push_pc <= fire;
      vec     <= vec_d;
      ack     <= ack_d;
    end
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int           N        = 8,
  parameter int           AW       = 16,
  parameter int           BASE     = 3,
  parameter int           STEP     = 8,
  parameter logic [N-1:0] ACK_MASK = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  en_i,
  input  logic          gie_i,
  input  logic [N-1:0]  prio_i,
  input  logic          insn_bnd_i,
  input  logic          reti_i,
  output logic          call_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          push_pc_o,
  output logic [N-1:0]  ack_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  cand, cand_hi, cand_lo;
  logic          hi_found, lo_found;
  logic [IW-1:0] hi_idx, lo_idx, win_idx;
  logic          busy_hi, busy_lo, skip;
  logic          gate, fire;
  grant_e        grant;

  assign cand    = req_i & en_i;
  assign cand_hi = cand & prio_i;
  assign cand_lo = cand & ~prio_i;

  ivc_pick #(.N(N), .IW(IW)) u_pick_hi (.cand(cand_hi), .found(hi_found), .idx(hi_idx));
  ivc_pick #(.N(N), .IW(IW)) u_pick_lo (.cand(cand_lo), .found(lo_found), .idx(lo_idx));

  always_comb begin
    gate  = insn_bnd_i && gie_i && !skip && !reti_i && !call_o;
    grant = GR_NONE;
    if (gate && hi_found && !busy_hi)                   grant = GR_HI;
    else if (gate && lo_found && !busy_hi && !busy_lo)  grant = GR_LO;
    fire    = (grant != GR_NONE);
    win_idx = (grant == GR_HI) ? hi_idx : lo_idx;
  end

  ivc_level_track u_track (
    .clk(clk), .rst_n(rst_n), .grant(grant), .reti(reti_i), .bnd(insn_bnd_i),
    .busy_hi(busy_hi), .busy_lo(busy_lo), .skip(skip)
  );

  ivc_vector_out #(
    .N(N), .IW(IW), .AW(AW), .BASE(BASE), .STEP(STEP), .ACK_MASK(ACK_MASK)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(win_idx),
    .call(call_o), .push_pc(push_pc_o), .vec(vec_addr_o), .ack(ack_o)
  );
endmodule

// File: rtl/ivc_checks.sv
module ivc_checks #(
  parameter int           N        = 8,
  parameter int           AW       = 16,
  parameter int           BASE     = 3,
  parameter int           STEP     = 8,
  parameter logic [N-1:0] ACK_MASK = 8'h0F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_o,
  input logic          push_pc_o,
  input logic [AW-1:0] vec_addr_o,
  input logic [N-1:0]  ack_o,
  input logic          insn_bnd_i,
  input logic          gie_i,
  input logic          reti_i
);
  // R2
  call_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |=> !call_o);
  // R2
  call_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ($past(insn_bnd_i) && $past(gie_i)));
  // R9
  call_after_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> !$past(reti_i));
  // R5
  push_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc_o == call_o);
  // R6
  ack_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o) && ((ack_o & ~ACK_MASK) == '0));
  // R6
  ack_in_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |-> call_o);
  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> ((vec_addr_o >= AW'(BASE)) && (((vec_addr_o - AW'(BASE)) % AW'(STEP)) == '0)));
  // R4
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !call_o |-> (vec_addr_o == '0));
endmodule

bind intr_vector_ctrl ivc_checks #(
  .N(N), .AW(AW), .BASE(BASE), .STEP(STEP), .ACK_MASK(ACK_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .call_o(call_o), .push_pc_o(push_pc_o),
  .vec_addr_o(vec_addr_o), .ack_o(ack_o), .insn_bnd_i(insn_bnd_i),
  .gie_i(gie_i), .reti_i(reti_i)
);

// File: tb/intr_vector_ctrl_test.sv
`timescale 1ns/1ps
module intr_vector_ctrl_test;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [N-1:0] MASK = 8'h0F;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req, en, prio;
  logic gie, bnd, reti;
  logic call, push;
  logic [AW-1:0] vec;
  logic [N-1:0] ack;

  int checks = 0;
  int fails = 0;

  logic m_hi, m_lo, m_skip, m_call;
  logic e_call, e_push;
  logic [AW-1:0] e_vec;
  logic [N-1:0] e_ack;

  always #5 clk = ~clk;

  intr_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .gie_i(gie), .prio_i(prio),
    .insn_bnd_i(bnd), .reti_i(reti), .call_o(call), .vec_addr_o(vec),
    .push_pc_o(push), .ack_o(ack)
  );

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // model of the next-cycle outputs from current inputs (R2, R3, R7, R8, R9)
  task automatic model_step();
    int w;
    logic [N-1:0] c;
    logic ok;
    w = -1;
    c = req & en;
    ok = bnd && gie && !m_skip && !reti && !m_call;
    if (ok && (c & prio) != '0 && !m_hi) begin
      w = lowest(c & prio);
    end else if (ok && (c & ~prio) != '0 && !m_hi && !m_lo) begin
      w = lowest(c & ~prio);
    end
    if (reti) begin
      if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
      m_skip = 1'b1;
    end else if (bnd && m_skip) begin
      m_skip = 1'b0;
    end
    if (w >= 0) begin
      if (prio[w]) m_hi = 1'b1; else m_lo = 1'b1;
    end
    e_call = (w >= 0);
    e_push = e_call;
    e_vec  = e_call ? AW'(3 + 8 * w) : '0;
    e_ack  = '0;
    if (e_call && MASK[w]) e_ack[w] = 1'b1;
    m_call = e_call;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (call !== e_call || push !== e_push || vec !== e_vec || ack !== e_ack) begin
      fails++;
      $display("FAIL %s: call=%b push=%b vec=%h ack=%b expected call=%b push=%b vec=%h ack=%b",
               tag, call, push, vec, ack, e_call, e_push, e_vec, e_ack);
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] e, input logic [N-1:0] p,
                     input logic g, input logic b, input logic rt, input string tag);
    req = r; en = e; prio = p; gie = g; bnd = b; reti = rt;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    req = '0; en = '0; prio = '0; gie = 1'b0; bnd = 1'b0; reti = 1'b0;
    m_hi = 0; m_lo = 0; m_skip = 0; m_call = 0;
    e_call = 0; e_push = 0; e_vec = '0; e_ack = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2: no decision without boundary or without global enable
    cyc(8'h04, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, "R2 no boundary");
    cyc(8'h04, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, "R2 gie low");
    // R3/R4/R6: low sources 2 and 5 -> 2 wins, vector 0x13, ack bit 2
    cyc(8'h24, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R3 R4 R6 low pick");
    // R2: boundary right after call takes nothing
    cyc(8'h80, 8'hFF, 8'h80, 1'b1, 1'b1, 1'b0, "R2 after call");
    // R7: high 6 preempts low; R6: no ack for software-cleared source
    cyc(8'h40, 8'hFF, 8'h40, 1'b1, 1'b1, 1'b0, "R7 R6 preempt");
    cyc(8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, "R5 idle");
    // R7: low blocked while busy, high blocked while high busy
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R7 low blocked");
    cyc(8'h02, 8'hFF, 8'h02, 1'b1, 1'b1, 1'b0, "R7 high blocked");
    // R8/R9: reti with boundary in same cycle, then skipped boundary
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, "R9 reti with boundary");
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R9 skipped boundary");
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R8 low still busy");
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, "R8 reti low");
    cyc(8'h01, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R9 skipped again");
    cyc(8'h01, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, "R4 source 0 vector");
    cyc(8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, "R8 clear");
    cyc(8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, "R9 skip");
    // R3: disabled source ignored, enabled one of equal level wins
    cyc(8'h81, 8'h80, 8'h00, 1'b1, 1'b1, 1'b0, "R3 enable mask");

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] r, e, p;
      logic g, b, rt;
      r  = N'($urandom) & N'($urandom);
      e  = N'($urandom) | N'($urandom);
      p  = N'($urandom);
      g  = ($urandom % 8) != 0;
      b  = ($urandom % 2) == 0;
      rt = (m_hi || m_lo) && (($urandom % 4) == 0);
      cyc(r, e, p, g, b, rt, "R2/R3/R4/R5/R6/R7/R8/R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule